// File: doc/BRIEF.md
# Linear Page Table Walker

This unit resolves a TLB miss in hardware. It keeps the table base register for the running process. When a miss arrives it forms the address of the entry: the base plus the virtual page number times the entry size. It issues one read on a simple request/response memory port. That port carries physical addresses only, so a walk never goes back through the TLB.

The returned entry holds a presence bit, four status bits and a 20-bit page number. A resident page produces a one-cycle refill strobe carrying the physical page number and the status bits. A non-resident page carries a disk page number in the same field. In that case the walk produces a one-cycle page-fault strobe carrying the disk page number, and no refill takes place, so software can bring the page in.

The walker serves one miss at a time and reports busy for the whole walk. A write to the base register is recorded at once. It applies from the next accepted miss onward.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `refill_valid` and `fault_valid` are all low.
- R2: The read address equals the base register value held when the miss is accepted, plus `miss_vpn` times 4 (the entry size is 32 bits = 4 bytes).
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, both `mem_req_valid` and `mem_req_addr` stay unchanged on the next cycle.
- R4: If bit 31 (presence) of the response is 1, `refill_valid` pulses for exactly one cycle, with `refill_ppn` = bits 19:0, `refill_status` = bits 30:27 (read, write, user, dirty from bit 30 down) and `refill_vpn` = the missing page number.
- R5: If bit 31 of the response is 0, `fault_valid` pulses for exactly one cycle, with `fault_dpn` = bits 19:0 and `fault_vpn` = the missing page number, and `refill_valid` stays low.
- R6: `busy` is high from the cycle after a miss is accepted until the walker is back in its idle state. Misses presented while `busy` is high are ignored.
- R7: A base register write made during a walk does not change that walk's address. It applies to the next walk.
- R8: Response data is taken only in a cycle with `mem_rsp_valid` high. Data present on other cycles has no effect.
- R9: Each walk issues exactly one accepted memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base (physical byte address) |
| miss_valid | input | 1 | A TLB miss is presented |
| miss_vpn | input | 20 | Virtual page number of the miss |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 32 | Physical address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| refill_valid | output | 1 | One-cycle TLB refill strobe |
| refill_vpn | output | 20 | Virtual page being refilled |
| refill_ppn | output | 20 | Physical page number |
| refill_status | output | 4 | Status bits: read, write, user, dirty |
| fault_valid | output | 1 | One-cycle page fault strobe |
| fault_vpn | output | 20 | Virtual page that faulted |
| fault_dpn | output | 20 | Disk page number of the missing page |

## Verification
A miss accepted on one edge raises `mem_req_valid` and `busy` in the next cycle. The request stays up until the edge on which `mem_req_ready` is seen. A response taken on an edge produces the refill or fault strobe in the following cycle, and the walker is idle one cycle after that. The bench drives and samples on the falling edge. After each rising edge it checks exactly the one cycle in which a result is due, and it also checks that the result is absent in the cycle after. The bench counts accepted requests per walk. It also holds stray data, extra misses and base writes on the inputs during waits, and checks that none of them alters the result.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
   parameter int PADDR_W     = 32,
   parameter int VPN_W       = 20,
   parameter int ENTRY_BYTES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_wr,
   input  logic [PADDR_W-1:0] base_wdata,
   input  logic               launch,
   input  logic [VPN_W-1:0]   vpn,
   output logic [PADDR_W-1:0] walk_addr
);

   localparam int SHIFT = $clog2(ENTRY_BYTES);
   localparam logic [PADDR_W-1:0] EB = PADDR_W'(ENTRY_BYTES);

   generate
      if (VPN_W + SHIFT > PADDR_W) begin : g_bad_width
         $error("pt_walker_addr: scaled page number wider than address");
      end
   endgenerate

   logic [PADDR_W-1:0] base_q;
   logic [PADDR_W-1:0] vpn_ext;
   logic [PADDR_W-1:0] offset;

   assign vpn_ext = {{(PADDR_W-VPN_W){1'b0}}, vpn};

   generate
      if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0) begin : g_shift
         assign offset = vpn_ext << SHIFT;
      end else begin : g_mult
         assign offset = vpn_ext * EB;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q    <= '0;
         walk_addr <= '0;
      end else begin
         if (base_wr)
            base_q <= base_wdata;
         if (launch)
            walk_addr <= base_q + offset;
      end
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> $stable(walk_addr)) else $error("walk address moved"); // R7

endmodule

// File: rtl/pt_walker_decode.sv
module pt_walker_decode #(
   parameter int PTE_W       = 32,
   parameter int PN_W        = 20,
   parameter int STAT_W      = 4,
   parameter int PRESENT_BIT = 31,
   parameter int STAT_LSB    = 27
) (
   input  logic [PTE_W-1:0]  pte,
   output logic              present,
   output logic [STAT_W-1:0] status,
   output logic [PN_W-1:0]   page_no
);

   generate
      if (PRESENT_BIT >= PTE_W || STAT_LSB + STAT_W > PRESENT_BIT || PN_W > STAT_LSB)
         begin : g_bad_layout
         $error("pt_walker_decode: entry fields overlap or exceed entry");
      end
   endgenerate

   logic unused_pte;

   assign present    = pte[PRESENT_BIT];
   assign status     = pte[STAT_LSB +: STAT_W];
   assign page_no    = pte[PN_W-1:0];
   assign unused_pte = ^pte;

endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
   import pt_walker_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic req_ready,
   input  logic rsp_valid,
   input  logic rsp_present,
   output logic launch,
   output logic capture,
   output logic busy,
   output logic req_valid,
   output logic refill_fire,
   output logic fault_fire
);

   walk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (miss_valid) state_d = ST_REQ;
         ST_REQ:   if (req_ready)  state_d = ST_WAIT;
         ST_WAIT:  if (rsp_valid)  state_d = rsp_present ? ST_DONE : ST_FAULT;
         ST_DONE:  state_d = ST_IDLE;
         ST_FAULT: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign launch      = (state_q == ST_IDLE) && miss_valid;
   assign capture     = (state_q == ST_WAIT) && rsp_valid;
   assign busy        = (state_q != ST_IDLE);
   assign req_valid   = (state_q == ST_REQ);
   assign refill_fire = (state_q == ST_DONE);
   assign fault_fire  = (state_q == ST_FAULT);

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_fire && fault_fire)) else $error("refill and fault together"); // R5
   AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      refill_fire |=> !refill_fire && !busy) else $error("refill not one cycle"); // R4
   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_fire |=> !fault_fire && !busy) else $error("fault not one cycle"); // R5
   AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy && req_valid) else $error("launch did not start walk"); // R6

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int PADDR_W     = 32,
   parameter int VPN_W       = 20,
   parameter int PTE_W       = 32,
   parameter int PN_W        = 20,
   parameter int STAT_W      = 4,
   parameter int PRESENT_BIT = 31,
   parameter int STAT_LSB    = 27
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_wr,
   input  logic [PADDR_W-1:0] base_wdata,
   input  logic               miss_valid,
   input  logic [VPN_W-1:0]   miss_vpn,
   output logic               busy,
   output logic               mem_req_valid,
   output logic [PADDR_W-1:0] mem_req_addr,
   input  logic               mem_req_ready,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               refill_valid,
   output logic [VPN_W-1:0]   refill_vpn,
   output logic [PN_W-1:0]    refill_ppn,
   output logic [STAT_W-1:0]  refill_status,
   output logic               fault_valid,
   output logic [VPN_W-1:0]   fault_vpn,
   output logic [PN_W-1:0]    fault_dpn
);

   localparam int ENTRY_BYTES = PTE_W / 8;

   generate
      if (PTE_W % 8 != 0) begin : g_bad_entry
         $error("pt_walker: entry width must be whole bytes");
      end
   endgenerate

   logic              launch, capture;
   logic              rsp_present;
   logic [STAT_W-1:0] rsp_status;
   logic [PN_W-1:0]   rsp_pn;
   logic [VPN_W-1:0]  vpn_q;
   logic [STAT_W-1:0] stat_q;
   logic [PN_W-1:0]   pn_q;

   pt_walker_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_valid  (miss_valid),
      .req_ready   (mem_req_ready),
      .rsp_valid   (mem_rsp_valid),
      .rsp_present (rsp_present),
      .launch      (launch),
      .capture     (capture),
      .busy        (busy),
      .req_valid   (mem_req_valid),
      .refill_fire (refill_valid),
      .fault_fire  (fault_valid)
   );

   pt_walker_addr #(
      .PADDR_W     (PADDR_W),
      .VPN_W       (VPN_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_wr    (base_wr),
      .base_wdata (base_wdata),
      .launch     (launch),
      .vpn        (miss_vpn),
      .walk_addr  (mem_req_addr)
   );

   pt_walker_decode #(
      .PTE_W       (PTE_W),
      .PN_W        (PN_W),
      .STAT_W      (STAT_W),
      .PRESENT_BIT (PRESENT_BIT),
      .STAT_LSB    (STAT_LSB)
   ) u_decode (
      .pte     (mem_rsp_data),
      .present (rsp_present),
      .status  (rsp_status),
      .page_no (rsp_pn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         stat_q <= '0;
         pn_q   <= '0;
      end else begin
         if (launch)
            vpn_q <= miss_vpn;
         if (capture) begin
            stat_q <= rsp_status;
            pn_q   <= rsp_pn;
         end
      end
   end

   assign refill_vpn    = vpn_q;
   assign refill_ppn    = pn_q;
   assign refill_status = stat_q;
   assign fault_vpn     = vpn_q;
   assign fault_dpn     = pn_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr))
      else $error("request dropped or changed"); // R3
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy) else $error("request outside walk"); // R6
   AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vpn_q)) else $error("miss taken while busy"); // R6
   AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid) else $error("second request"); // R9
   AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refill_valid) || $rose(fault_valid) |-> $past(mem_rsp_valid))
      else $error("result without response"); // R8

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        miss_valid = 1'b0;
   logic [19:0] miss_vpn = '0;
   logic        busy, mem_req_valid, mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        refill_valid, fault_valid;
   logic [19:0] refill_vpn, refill_ppn, fault_vpn, fault_dpn;
   logic [3:0]  refill_status;

   int checks = 0;
   int errors = 0;
   int req_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   always @(posedge clk)
      if (rst_n && mem_req_valid && mem_req_ready) req_cnt++;

   pt_walker u_pt_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .base_wr       (base_wr),
      .base_wdata    (base_wdata),
      .miss_valid    (miss_valid),
      .miss_vpn      (miss_vpn),
      .busy          (busy),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .refill_valid  (refill_valid),
      .refill_vpn    (refill_vpn),
      .refill_ppn    (refill_ppn),
      .refill_status (refill_status),
      .fault_valid   (fault_valid),
      .fault_vpn     (fault_vpn),
      .fault_dpn     (fault_dpn)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_base(input logic [31:0] b);
      base_wr = 1'b1; base_wdata = b;
      step();
      base_wr = 1'b0;
   endtask

   // One walk: miss, request with ready delay, response after delay with
   // stray data, optional intruding miss and base write, then result checks.
   task automatic walk(input logic [19:0] vpn, input logic [31:0] pte,
                       input logic [31:0] base, input int rdy_dly, input int rsp_dly,
                       input bit intrude, input bit rebase, input logic [31:0] nbase);
      int start_cnt;
      logic [31:0] exp_addr;
      exp_addr = base + {10'd0, vpn, 2'b00};
      start_cnt = req_cnt;
      miss_vpn = vpn; miss_valid = 1'b1;
      step();
      miss_valid = 1'b0;
      check("R6", "busy after accept", {63'd0, busy}, 64'd1);
      check("R2", "request address", {32'd0, mem_req_addr}, {32'd0, exp_addr});
      if (rebase) set_base(nbase);
      for (int i = 0; i < rdy_dly; i++) begin
         step();
         check("R3", "request held", {31'd0, mem_req_valid, mem_req_addr},
               {31'd0, 1'b1, exp_addr});
      end
      mem_req_ready = 1'b1;
      step();
      mem_req_ready = 1'b0;
      check("R9", "request dropped after accept", {63'd0, mem_req_valid}, 64'd0);
      if (intrude) begin
         miss_valid = 1'b1; miss_vpn = ~vpn;
      end
      for (int i = 0; i < rsp_dly; i++) begin
         mem_rsp_data = ~pte;
         step();
         check("R8", "no result before response",
               {62'd0, refill_valid, fault_valid}, 64'd0);
      end
      miss_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      step();
      mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
      if (pte[31]) begin
         check("R4", "refill strobe", {62'd0, refill_valid, fault_valid}, 64'd2);
         check("R4", "refill fields", {refill_vpn, refill_ppn, refill_status},
               {vpn, pte[19:0], pte[30:27]});
      end else begin
         check("R5", "fault strobe", {62'd0, refill_valid, fault_valid}, 64'd1);
         check("R5", "fault fields", {24'd0, fault_vpn, fault_dpn},
               {24'd0, vpn, pte[19:0]});
      end
      step();
      check("R4", "strobes one cycle", {62'd0, refill_valid, fault_valid}, 64'd0);
      check("R6", "idle after walk", {62'd0, busy, mem_req_valid}, 64'd0);
      check("R9", "one request per walk", 64'(req_cnt - start_cnt), 64'd1);
   endtask

   task automatic t_reset();
      check("R1", "reset outputs",
            {60'd0, busy, mem_req_valid, refill_valid, fault_valid}, 64'd0);
   endtask

   task automatic t_basic_refill();
      set_base(32'h0010_0000);
      walk(20'h00005, 32'hC000_0ABC, 32'h0010_0000, 0, 0, 0, 0, '0); // R2 R4
   endtask

   task automatic t_stalls();
      walk(20'h01234, 32'hA800_7F00, 32'h0010_0000, 3, 4, 0, 0, '0); // R3 R8
   endtask

   task automatic t_fault();
      walk(20'h00077, 32'h7000_0042, 32'h0010_0000, 1, 2, 0, 0, '0); // R5
   endtask

   task automatic t_busy_ignore();
      walk(20'h00300, 32'h9000_0001, 32'h0010_0000, 2, 3, 1, 0, '0); // R6
   endtask

   task automatic t_rebase();
      walk(20'h00010, 32'h8800_0010, 32'h0010_0000, 2, 1, 0, 1, 32'h0200_0000); // R7
      walk(20'h00010, 32'h8800_0011, 32'h0200_0000, 0, 0, 0, 0, '0);           // R7
   endtask

   task automatic t_bounds();
      set_base(32'h8000_0000);
      walk(20'hFFFFF, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, 0, 0, '0); // R2 R4
      walk(20'h00000, 32'h780F_FFFF, 32'h8000_0000, 1, 0, 0, 0, '0); // R5
   endtask

   initial begin
      @(negedge clk);
      step();
      step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic_refill();
      t_stalls();
      t_fault();
      t_busy_ignore();
      t_rebase();
      t_bounds();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule